// File: doc/BRIEF.md
# Masked CAM Event Detector

This block watches a stream of observed addresses or event codes. Each cycle in which the observation is marked valid, it compares the code against a small bank of programmable entries. Every entry holds a match value and a care mask: bits whose care bit is 0 are ignored, so one entry can cover a whole aligned address range. A bit with care set to 1 must equal the stored value. A hit advances a prescale counter belonging to the winning entry. A notification, which carries the entry index and the entry's handler address, is raised only on every Nth hit. The block does not screen out hits that are false for the consumer's purpose; whatever logic receives the notification decides.

Entries are loaded one at a time through a write port that supplies every field in a single cycle. An entry is live only while its handler address is nonzero, so writing a zero handler switches it off. An entry can also be flagged as a watchpoint. When such an entry issues a notification, the block raises a stall request towards the execution core. The request stays up until a resume pulse names that same entry.

Top module: `evt_cam_detector`

## Requirements
- R1: After reset no entry is live: `notify_valid` and `stall_req` are 0, and no observation produces a notification until an entry has been written with a nonzero handler.
- R2: An entry hits when `(obs_code ^ value) & care == 0`. Care bits of 0 are don't-care, so a single entry covers every code that differs from its value only in those bits. A code that differs in a cared bit does not hit.
- R3: An entry whose handler field is zero never hits. Writing a zero handler to a live entry turns it off.
- R4: With prescale N ≥ 1, only every Nth hit of an entry produces a notification; the N−1 hits before it are suppressed. A prescale of 0 behaves like 1.
- R5: When several entries hit in the same cycle, the lowest index wins. Only the winner's counter advances and only the winner may notify.
- R6: A notification appears as a one-cycle `notify_valid` pulse on the cycle after the valid observation. It carries `notify_idx` and `notify_handler` of the winning entry. Both fields read 0 when no notification is issued.
- R7: When an entry with its watchpoint bit set issues a notification, `stall_req` rises in that same output cycle. It stays high until `resume_valid` arrives with `resume_idx` equal to that entry. A resume naming any other entry leaves the stall in place.
- R8: Writing an entry clears its prescale counter, so the next N hits count from zero. It also clears any stall pending for that entry. While an entry is being written, that entry does not hit in the same cycle.
- R9: Observations with `obs_valid` low change nothing: no notification is issued and no counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | Observed code is valid this cycle |
| obs_code | input | DW (32) | Observed address or event code |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | IW (3) | Entry to load |
| wr_value | input | DW (32) | Match value |
| wr_care | input | DW (32) | Care mask, 1 = bit compared |
| wr_count | input | PW (16) | Prescale N |
| wr_handler | input | HW (16) | Handler address, 0 = entry off |
| wr_watch | input | 1 | Entry is a watchpoint |
| resume_valid | input | 1 | Release a stalled entry |
| resume_idx | input | IW (3) | Entry to release |
| notify_valid | output | 1 | Notification pulse |
| notify_idx | output | IW (3) | Winning entry index |
| notify_handler | output | HW (16) | Handler address of winning entry |
| stall_req | output | 1 | Stall request to the execution core |

## Verification
The assertions take for granted that the write and resume ports carry indices below the entry count. They also assume that `rst_n` is low across the first clock edge, so that every stored field starts from a known value. The stimulus writes only existing entries and drives all inputs on the falling edge. It holds the write port idle during observations, except in the one test that aims a write and a hit at the same entry in the same cycle. Resume pulses last exactly one cycle and are aimed either at a stalled entry or at one that is deliberately wrong.

// File: rtl/evt_cam_detector.sv
module evt_cam_detector #(
  parameter int ENTRIES = 8,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int HW = 16,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          obs_valid,
  input  logic [DW-1:0] obs_code,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_value,
  input  logic [DW-1:0] wr_care,
  input  logic [PW-1:0] wr_count,
  input  logic [HW-1:0] wr_handler,
  input  logic          wr_watch,
  input  logic          resume_valid,
  input  logic [IW-1:0] resume_idx,
  output logic          notify_valid,
  output logic [IW-1:0] notify_idx,
  output logic [HW-1:0] notify_handler,
  output logic          stall_req
);

  logic [DW-1:0] val_q  [ENTRIES];
  logic [DW-1:0] care_q [ENTRIES];
  logic [PW-1:0] lim_q  [ENTRIES];
  logic [PW-1:0] cnt_q  [ENTRIES];
  logic [HW-1:0] hnd_q  [ENTRIES];
  logic [ENTRIES-1:0] watch_q, pend_q, hit, last;
  logic [PW-1:0] top [ENTRIES];

  logic          win_found;
  logic [IW-1:0] win_idx;
  logic          fire;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      top[i]  = (lim_q[i] == '0) ? '0 : lim_q[i] - 1'b1;
      last[i] = (cnt_q[i] >= top[i]);
      hit[i]  = obs_valid && (hnd_q[i] != '0)
                && !(wr_en && wr_idx == IW'(i))
                && (((obs_code ^ val_q[i]) & care_q[i]) == '0);
    end
  end

  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_found = 1'b1;
        win_idx   = IW'(i);
      end
    end
  end

  assign fire      = win_found && last[win_idx];
  assign stall_req = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        val_q[i]  <= '0;
        care_q[i] <= '0;
        lim_q[i]  <= '0;
        cnt_q[i]  <= '0;
        hnd_q[i]  <= '0;
      end
      watch_q <= '0;
      pend_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && wr_idx == IW'(i)) begin
          val_q[i]   <= wr_value;
          care_q[i]  <= wr_care;
          lim_q[i]   <= wr_count;
          hnd_q[i]   <= wr_handler;
          watch_q[i] <= wr_watch;
          cnt_q[i]   <= '0;
          pend_q[i]  <= 1'b0;
        end else begin
          if (win_found && win_idx == IW'(i))
            cnt_q[i] <= last[i] ? '0 : cnt_q[i] + 1'b1;
          if (fire && win_idx == IW'(i) && watch_q[i])
            pend_q[i] <= 1'b1;
          else if (resume_valid && resume_idx == IW'(i))
            pend_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_valid   <= 1'b0;
      notify_idx     <= '0;
      notify_handler <= '0;
    end else begin
      notify_valid   <= fire;
      notify_idx     <= fire ? win_idx : '0;
      notify_handler <= fire ? hnd_q[win_idx] : '0;
    end
  end

  assert_notify_after_obs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(obs_valid));

  assert_notify_live_handler_R3: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> notify_handler != '0);

  assert_stall_rises_with_notify_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_req) |-> notify_valid);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !resume_valid && !wr_en) |=> stall_req);

  assert_quiet_without_obs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(obs_valid) |-> !notify_valid);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    assert_prescale_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= top[g]);
  end

endmodule

// File: tb/evt_cam_detector_tb_top.sv
module evt_cam_detector_tb_top;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obs_valid = 1'b0;
  logic [31:0] obs_code = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_value = '0, wr_care = '0;
  logic [15:0] wr_count = '0, wr_handler = '0;
  logic wr_watch = 1'b0;
  logic resume_valid = 1'b0;
  logic [IW-1:0] resume_idx = '0;
  logic notify_valid, stall_req;
  logic [IW-1:0] notify_idx;
  logic [15:0] notify_handler;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  evt_cam_detector dut_i (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_code(obs_code),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value), .wr_care(wr_care),
    .wr_count(wr_count), .wr_handler(wr_handler), .wr_watch(wr_watch),
    .resume_valid(resume_valid), .resume_idx(resume_idx),
    .notify_valid(notify_valid), .notify_idx(notify_idx),
    .notify_handler(notify_handler), .stall_req(stall_req));

  // code, expected notify, expected index
  localparam logic [35:0] VEC [9] = '{
    {32'h1000_0004, 1'b1, 3'd0},
    {32'h1000_0805, 1'b1, 3'd0},
    {32'h2000_0000, 1'b0, 3'd0},
    {32'h2000_0000, 1'b0, 3'd0},
    {32'h2000_0000, 1'b1, 3'd2},
    {32'h2000_0001, 1'b0, 3'd0},
    {32'h3000_0000, 1'b0, 3'd0},
    {32'h1000_1000, 1'b0, 3'd0},
    {32'h2000_0000, 1'b0, 3'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [IW-1:0] idx, input logic [31:0] v, input logic [31:0] c,
                      input logic [15:0] n, input logic [15:0] h, input logic w);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_value = v; wr_care = c;
    wr_count = n; wr_handler = h; wr_watch = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic observe(input logic [31:0] code);
    @(negedge clk);
    obs_valid = 1'b1; obs_code = code;
    @(negedge clk);
    obs_valid = 1'b0;
  endtask

  task automatic resume(input logic [IW-1:0] idx);
    @(negedge clk);
    resume_valid = 1'b1; resume_idx = idx;
    @(negedge clk);
    resume_valid = 1'b0;
  endtask

  function automatic logic [31:0] nv();
    return {28'd0, notify_valid, notify_idx};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset notify", {31'd0, notify_valid}, 32'd0);
    check("R1 reset stall", {31'd0, stall_req}, 32'd0);
    observe(32'h0);
    check("R1 no live entry", nv(), 32'd0);

    prog(3'd0, 32'h1000_0000, 32'hFFFF_F000, 16'd1, 16'h0100, 1'b0);
    prog(3'd1, 32'h1000_0800, 32'hFFFF_FF00, 16'd1, 16'h0200, 1'b0);
    prog(3'd2, 32'h2000_0000, 32'hFFFF_FFFF, 16'd3, 16'h0300, 1'b0);
    prog(3'd3, 32'h3000_0000, 32'hF000_0000, 16'd1, 16'h0000, 1'b0);

    // R2 R4 R5 R3 table walk
    for (int k = 0; k < 9; k++) begin
      observe(VEC[k][35:4]);
      check($sformatf("R2/R4/R5 vector %0d", k), nv(), {28'd0, VEC[k][3:0]});
    end

    observe(32'h1000_0010);
    check("R6 handler", {16'd0, notify_handler}, 32'h0100);
    @(negedge clk);
    check("R6 single pulse", {31'd0, notify_valid}, 32'd0);
    check("R6 idle handler zero", {16'd0, notify_handler}, 32'd0);

    prog(3'd0, 32'h1000_0000, 32'hFFFF_F000, 16'd1, 16'h0000, 1'b0);
    observe(32'h1000_0805);
    check("R3 disabled entry0, entry1 wins", nv(), {28'd0, 1'b1, 3'd1});
    check("R3 entry1 handler", {16'd0, notify_handler}, 32'h0200);

    // R8: entry2 holds one counted hit; rewrite clears it
    prog(3'd2, 32'h2000_0000, 32'hFFFF_FFFF, 16'd3, 16'h0300, 1'b0);
    observe(32'h2000_0000);
    observe(32'h2000_0000);
    check("R8 counter cleared", nv(), 32'd0);
    observe(32'h2000_0000);
    check("R8 third hit", nv(), {28'd0, 1'b1, 3'd2});

    // R9
    @(negedge clk);
    obs_code = 32'h1000_0805; obs_valid = 1'b0;
    @(negedge clk);
    check("R9 invalid ignored", nv(), 32'd0);

    // R4 prescale zero acts as one
    prog(3'd5, 32'h0000_0005, 32'hFFFF_FFFF, 16'd0, 16'h0500, 1'b0);
    observe(32'h5);
    check("R4 N=0 first", nv(), {28'd0, 1'b1, 3'd5});
    observe(32'h5);
    check("R4 N=0 second", nv(), {28'd0, 1'b1, 3'd5});

    // R7 watchpoint
    prog(3'd4, 32'h4000_0000, 32'hFFFF_FFFF, 16'd2, 16'h0400, 1'b1);
    observe(32'h4000_0000);
    check("R7 no stall before Nth", {31'd0, stall_req}, 32'd0);
    observe(32'h4000_0000);
    check("R7 notify", nv(), {28'd0, 1'b1, 3'd4});
    check("R7 stall raised", {31'd0, stall_req}, 32'd1);
    resume(3'd3);
    check("R7 wrong resume ignored", {31'd0, stall_req}, 32'd1);
    resume(3'd4);
    check("R7 released", {31'd0, stall_req}, 32'd0);

    observe(32'h4000_0000);
    observe(32'h4000_0000);
    check("R8 stall again", {31'd0, stall_req}, 32'd1);
    prog(3'd4, 32'h4000_0000, 32'hFFFF_FFFF, 16'd2, 16'h0400, 1'b1);
    check("R8 rewrite clears stall", {31'd0, stall_req}, 32'd0);

    // R8 same-cycle write blocks the hit on that entry
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_value = 32'h5; wr_care = '1;
    wr_count = 16'd1; wr_handler = 16'h0500; wr_watch = 1'b0;
    obs_valid = 1'b1; obs_code = 32'h5;
    @(negedge clk);
    wr_en = 1'b0; obs_valid = 1'b0;
    check("R8 write blocks same-cycle hit", nv(), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule